// File: doc/BRIEF.md
# Multi-Channel Packet Demultiplexer

This block is the single reader of an upstream word buffer that has already been brought into the local clock domain. The buffer carries fixed-length packets (by default 256 words of 16 bits, or 512 bytes). Data packets for different transmit channels and control packets can arrive in any order. The block reads one header word per packet and uses its channel field to pick a destination. Data payloads go into a per-channel FIFO as a record. Control payloads go into one shared command FIFO. Packets addressed to a channel that is not implemented are discarded.

Each data record is written as three parts in a fixed order: the timestamp word, then a word holding the number of samples, then the samples themselves. Any words after the declared payload, up to the end of the packet, are padding and are read and thrown away. When the destination FIFO is full, reading from the upstream buffer pauses. No word is ever lost.

Top module: `pkt_demux`

## Requirements
- R1: After reset every channel FIFO and the command FIFO report empty, the error flag is 0, and no word is read while the upstream buffer is empty.
- R2: Word 0 of each packet is the header. Bits [3:0] hold the channel number and bits [15:8] hold the payload length L. Channel value 15 marks a control packet. Channels 0 to NUM_CH-1 are data channels.
- R3: A data packet carries its timestamp in word 1 and its samples from word 2 onward. The addressed channel FIFO receives, in this order, the timestamp, the effective sample count, and then that many samples in arrival order.
- R4: For a control packet, payload words 1..L enter the command FIFO in arrival order. No channel FIFO is written.
- R5: Every packet occupies exactly PKT_WORDS input words. Words after the payload are discarded, and the next header is taken from the word that follows.
- R6: The payload length is clamped to the space in the packet: at most PKT_WORDS-2 samples for data and PKT_WORDS-1 words for control. A clamped data record carries the clamped count.
- R7: Each packet is routed on its own header. Packets for different channels and control packets may be interleaved at packet granularity. At most one destination is written per cycle.
- R8: When the current destination FIFO is full, the block stops reading input and does not write that FIFO. Reading resumes once space frees, and no word is lost.
- R9: A channel number at or above NUM_CH (other than 15) causes the whole packet to be discarded. It also sets the error flag, which stays set until reset. Later packets are routed normally.
- R10: The input read strobe is asserted only while the upstream buffer shows a valid word. At most one word is consumed per cycle.
- R11: A data packet with L = 0 produces a record of the timestamp followed by a count word of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream buffer holds a word |
| in_data | input | W | Upstream head word (show-ahead) |
| in_rd | output | 1 | Consume the upstream head word |
| ch_rd | input | NUM_CH | Per-channel FIFO read strobe |
| ch_data | output | NUM_CH*W | Per-channel FIFO head words, channel i at bits [i*W +: W] |
| ch_empty | output | NUM_CH | Per-channel FIFO empty |
| cmd_rd | input | 1 | Command FIFO read strobe |
| cmd_data | output | W | Command FIFO head word |
| cmd_empty | output | 1 | Command FIFO empty |
| err_bad_chan | output | 1 | Sticky flag for an unimplemented channel number |

## Verification
The test patterns are:
- A lone short data packet and a lone control packet. These show that the header field selects the destination and that padding is skipped.
- An interleaved run of channel 0, channel 1, channel 0 and control packets. A mix-up of per-packet state or a stale channel latch shows up here.
- Over-long and zero lengths. These separate the clamped count from the raw field and check the two-word record.
- A full-length packet with no reader. This should stall after a predictable number of consumed words, and a later drain recovers every sample, so a drop and a wedge can be told apart.
- An unimplemented channel followed by a valid packet. This shows that the discard resynchronises on packet length and that the error flag is sticky.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
   typedef enum logic [2:0] {
      ST_HDR,
      ST_TS,
      ST_CNT,
      ST_DATA,
      ST_CMD,
      ST_DROP
   } pdx_state_e;
endpackage

// File: rtl/pdx_fifo.sv
module pdx_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("pdx_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_wr, do_rd;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/pdx_parser.sv
module pdx_parser
   import pdx_pkg::*;
#(
   parameter int W         = 16,
   parameter int PKT_WORDS = 256,
   parameter int NUM_CH    = 2,
   parameter int CH_W      = 4,
   parameter int LEN_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [W-1:0]      in_data,
   output logic              in_rd,
   input  logic [NUM_CH-1:0] dst_full,
   input  logic              cmd_full,
   output logic [W-1:0]      wr_data,
   output logic [NUM_CH-1:0] ch_wr,
   output logic              cmd_wr,
   output logic              err_bad_chan
);
   localparam int POS_W = $clog2(PKT_WORDS);
   localparam logic [CH_W-1:0] CMD_ID = {CH_W{1'b1}};
   localparam int MAX_DAT = PKT_WORDS - 2;
   localparam int MAX_CMD = PKT_WORDS - 1;

   pdx_state_e        state;
   logic [POS_W-1:0]  pos;
   logic [POS_W-1:0]  remain;
   logic [CH_W-1:0]   chan;
   logic [NUM_CH-1:0] sel;
   logic              sel_full, last;
   logic [CH_W-1:0]   hdr_chan;
   logic [LEN_W-1:0]  hdr_len;
   logic [POS_W-1:0]  eff_dat, eff_cmd;
   logic              hdr_is_cmd, hdr_is_ok;

   assign hdr_chan   = in_data[CH_W-1:0];
   assign hdr_len    = in_data[W-1 -: LEN_W];
   assign hdr_is_cmd = (hdr_chan == CMD_ID);
   assign hdr_is_ok  = (int'(hdr_chan) < NUM_CH);
   assign last       = (pos == POS_W'(PKT_WORDS - 1));

   always_comb begin
      eff_dat = (int'(hdr_len) > MAX_DAT) ? POS_W'(MAX_DAT) : POS_W'(hdr_len);
      eff_cmd = (int'(hdr_len) > MAX_CMD) ? POS_W'(MAX_CMD) : POS_W'(hdr_len);
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign sel[i] = (chan == CH_W'(i));
   end
   assign sel_full = |(sel & dst_full);

   always_comb begin
      in_rd   = 1'b0;
      ch_wr   = '0;
      cmd_wr  = 1'b0;
      wr_data = in_data;
      case (state)
         ST_HDR:  in_rd = in_valid;
         ST_TS: begin
            if (in_valid && !sel_full) begin
               in_rd = 1'b1;
               ch_wr = sel;
            end
         end
         ST_CNT: begin
            wr_data = W'(remain);
            if (!sel_full) ch_wr = sel;
         end
         ST_DATA: begin
            if (in_valid && !sel_full) begin
               in_rd = 1'b1;
               ch_wr = sel;
            end
         end
         ST_CMD: begin
            if (in_valid && !cmd_full) begin
               in_rd  = 1'b1;
               cmd_wr = 1'b1;
            end
         end
         ST_DROP: in_rd = in_valid;
         default: in_rd = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_HDR;
         pos          <= '0;
         remain       <= '0;
         chan         <= '0;
         err_bad_chan <= 1'b0;
      end else begin
         if (in_rd) pos <= last ? '0 : pos + 1'b1;
         case (state)
            ST_HDR: begin
               if (in_rd) begin
                  chan <= hdr_chan;
                  if (hdr_is_cmd) begin
                     remain <= eff_cmd;
                     state  <= (eff_cmd != '0) ? ST_CMD : ST_DROP;
                  end else if (hdr_is_ok) begin
                     remain <= eff_dat;
                     state  <= ST_TS;
                  end else begin
                     err_bad_chan <= 1'b1;
                     state        <= ST_DROP;
                  end
               end
            end
            ST_TS: if (in_rd) state <= ST_CNT;
            ST_CNT: begin
               if (ch_wr != '0) state <= (remain != '0) ? ST_DATA : ST_DROP;
            end
            ST_DATA, ST_CMD: begin
               if (in_rd) begin
                  remain <= remain - 1'b1;
                  if (last)                          state <= ST_HDR;
                  else if (remain == POS_W'(1))      state <= ST_DROP;
               end
            end
            ST_DROP: if (in_rd && last) state <= ST_HDR;
            default: state <= ST_HDR;
         endcase
      end
   end
endmodule

// File: rtl/pkt_demux.sv
module pkt_demux #(
   parameter int W         = 16,
   parameter int PKT_WORDS = 256,
   parameter int NUM_CH    = 2,
   parameter int CH_W      = 4,
   parameter int LEN_W     = 8,
   parameter int CH_DEPTH  = 512,
   parameter int CMD_DEPTH = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [W-1:0]        in_data,
   output logic                in_rd,
   input  logic [NUM_CH-1:0]   ch_rd,
   output logic [NUM_CH*W-1:0] ch_data,
   output logic [NUM_CH-1:0]   ch_empty,
   input  logic                cmd_rd,
   output logic [W-1:0]        cmd_data,
   output logic                cmd_empty,
   output logic                err_bad_chan
);
   if (PKT_WORDS < 4) begin : g_chk_pkt
      $error("pkt_demux: PKT_WORDS must be at least 4");
   end
   if (CH_W + LEN_W > W) begin : g_chk_fields
      $error("pkt_demux: header fields exceed word width");
   end
   if (NUM_CH < 1 || NUM_CH >= (1 << CH_W)) begin : g_chk_ch
      $error("pkt_demux: NUM_CH must fit below the control channel code");
   end
   if ($clog2(PKT_WORDS) >= W) begin : g_chk_cnt
      $error("pkt_demux: count word cannot hold packet length");
   end

   logic [W-1:0]      wr_data;
   logic [NUM_CH-1:0] ch_wr, ch_full;
   logic              cmd_wr, cmd_full;

   pdx_parser #(
      .W(W), .PKT_WORDS(PKT_WORDS), .NUM_CH(NUM_CH), .CH_W(CH_W), .LEN_W(LEN_W)
   ) u_parse (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_rd(in_rd),
      .dst_full(ch_full), .cmd_full(cmd_full),
      .wr_data(wr_data), .ch_wr(ch_wr), .cmd_wr(cmd_wr),
      .err_bad_chan(err_bad_chan)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pdx_fifo #(.W(W), .DEPTH(CH_DEPTH)) u_fifo (
         .clk(clk), .rst_n(rst_n),
         .wr(ch_wr[i]), .wdata(wr_data),
         .rd(ch_rd[i]), .rdata(ch_data[i*W +: W]),
         .full(ch_full[i]), .empty(ch_empty[i])
      );
   end

   pdx_fifo #(.W(W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr(cmd_wr), .wdata(wr_data),
      .rd(cmd_rd), .rdata(cmd_data),
      .full(cmd_full), .empty(cmd_empty)
   );
endmodule

// File: rtl/pdx_chk.sv
module pdx_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_rd,
   input logic [NUM_CH-1:0] ch_wr,
   input logic [NUM_CH-1:0] ch_full,
   input logic              cmd_wr,
   input logic              cmd_full,
   input logic              err_bad_chan
);
   AST_RD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd |-> in_valid);                                           // R10
   AST_CH_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr & ch_full) == '0);                                      // R8
   AST_CMD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> !cmd_full);                                         // R8
   AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ch_wr, cmd_wr}));                                    // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_chan |=> err_bad_chan);                                // R9
endmodule

bind pkt_demux pdx_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd),
   .ch_wr(ch_wr), .ch_full(ch_full), .cmd_wr(cmd_wr), .cmd_full(cmd_full),
   .err_bad_chan(err_bad_chan)
);

// File: tb/sim_pkt_demux.sv
`timescale 1ns/1ps
module sim_pkt_demux;
   localparam int W = 16, P = 16, NCH = 2, DEP = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid, in_rd;
   logic [W-1:0] in_data;
   logic [NCH-1:0] ch_rd = '0;
   logic [NCH*W-1:0] ch_data;
   logic [NCH-1:0] ch_empty;
   logic cmd_rd = 1'b0, cmd_empty, err_bad_chan;
   logic [W-1:0] cmd_data;

   int checks = 0, fails = 0, rd_viol = 0;
   logic [15:0] q [1024];
   int qn = 0, qi = 0;
   bit took = 1'b0;

   always #2.5 clk = ~clk;

   pkt_demux #(.W(W), .PKT_WORDS(P), .NUM_CH(NCH), .CH_W(4), .LEN_W(8),
               .CH_DEPTH(DEP), .CMD_DEPTH(DEP)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_rd(in_rd), .ch_rd(ch_rd), .ch_data(ch_data), .ch_empty(ch_empty),
      .cmd_rd(cmd_rd), .cmd_data(cmd_data), .cmd_empty(cmd_empty),
      .err_bad_chan(err_bad_chan));

   assign in_valid = (qi < qn);
   assign in_data  = in_valid ? q[qi[9:0]] : '0;

   // upstream model: consumption decided by in_rd just before each rising edge
   always @(negedge clk) begin
      if (took) qi++;
      #1;
      took = rst_n && in_rd;
      if (in_rd && !in_valid) rd_viol++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_pkt(input int chan, input int len, input int ts, input int seed);
      @(negedge clk);
      q[qn[9:0]] = {len[7:0], 4'h0, chan[3:0]}; qn++;
      if (chan == 15) begin
         for (int k = 0; k < P - 1; k++) begin q[qn[9:0]] = 16'(seed + k); qn++; end
      end else begin
         q[qn[9:0]] = 16'(ts); qn++;
         for (int k = 0; k < P - 2; k++) begin q[qn[9:0]] = 16'(seed + k); qn++; end
      end
   endtask

   task automatic pop(input int dest, output logic [15:0] w);
      int t = 0;
      w = 16'hDEAD;
      forever begin
         @(negedge clk);
         if (dest == NCH ? !cmd_empty : !ch_empty[dest]) break;
         t++;
         if (t > 3000) return;
      end
      if (dest == NCH) begin w = cmd_data; cmd_rd = 1'b1; end
      else begin w = ch_data[dest*W +: W]; ch_rd[dest] = 1'b1; end
      @(negedge clk);
      cmd_rd = 1'b0; ch_rd = '0;
   endtask

   task automatic expect_data(input int ch, input int ts, input int len,
                              input int seed, input string req);
      logic [15:0] w;
      int eff = (len > P - 2) ? P - 2 : len;
      pop(ch, w); chk(w == 16'(ts), req, "timestamp word", w, ts);
      pop(ch, w); chk(w == 16'(eff), req, "count word", w, eff);
      for (int k = 0; k < eff; k++) begin
         pop(ch, w); chk(w == 16'(seed + k), req, "sample word", w, seed + k);
      end
   endtask

   task automatic expect_cmd(input int len, input int seed, input string req);
      logic [15:0] w;
      int eff = (len > P - 1) ? P - 1 : len;
      for (int k = 0; k < eff; k++) begin
         pop(NCH, w); chk(w == 16'(seed + k), req, "command word", w, seed + k);
      end
   endtask

   task automatic wait_idle();
      while (qi < qn) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_all_empty(input string req);
      chk(ch_empty == '1 && cmd_empty, req, "all FIFOs empty",
          {ch_empty, cmd_empty}, {NCH+1{1'b1}});
   endtask

   task automatic t_reset();   // R1
      repeat (3) @(negedge clk);
      expect_all_empty("R1");
      chk(err_bad_chan == 1'b0, "R1", "error flag", err_bad_chan, 0);
      chk(in_rd == 1'b0, "R1", "read while empty", in_rd, 0);
   endtask

   task automatic t_single();  // R2 R3 R5
      push_pkt(0, 5, 16'h1234, 16'h0100);
      push_pkt(1, 3, 16'h4321, 16'h0200);
      expect_data(0, 16'h1234, 5, 16'h0100, "R3");
      expect_data(1, 16'h4321, 3, 16'h0200, "R2");
      wait_idle();
      expect_all_empty("R5");
      chk(qi == qn, "R5", "whole packets consumed", qi, qn);
   endtask

   task automatic t_cmd();     // R4
      push_pkt(15, 3, 0, 16'h0C00);
      wait_idle();
      chk(ch_empty == '1, "R4", "no channel write", ch_empty, 2'b11);
      expect_cmd(3, 16'h0C00, "R4");
      expect_all_empty("R4");
   endtask

   task automatic t_interleave(); // R7
      push_pkt(0, 2, 16'hA000, 16'h0A00);
      push_pkt(1, 2, 16'hB000, 16'h0B00);
      push_pkt(0, 2, 16'hA001, 16'h0A10);
      push_pkt(15, 2, 0, 16'h0C10);
      expect_data(0, 16'hA000, 2, 16'h0A00, "R7");
      expect_data(0, 16'hA001, 2, 16'h0A10, "R7");
      expect_data(1, 16'hB000, 2, 16'h0B00, "R7");
      expect_cmd(2, 16'h0C10, "R7");
      wait_idle();
      expect_all_empty("R7");
   endtask

   task automatic t_clamp();   // R6
      push_pkt(1, 200, 16'h5555, 16'h0300);
      expect_data(1, 16'h5555, 200, 16'h0300, "R6");
      push_pkt(15, 255, 0, 16'h0D00);
      expect_cmd(255, 16'h0D00, "R6");
      wait_idle();
      expect_all_empty("R6");
   endtask

   task automatic t_zero();    // R11
      push_pkt(0, 0, 16'h7777, 16'h0400);
      expect_data(0, 16'h7777, 0, 0, "R11");
      wait_idle();
      expect_all_empty("R11");
   endtask

   task automatic t_stall();   // R8
      int base = qn;
      push_pkt(0, 14, 16'h9999, 16'h0500);
      repeat (60) @(negedge clk);
      chk(qi - base == 8, "R8", "words consumed before stall", qi - base, 8);
      chk(in_rd == 1'b0, "R8", "read strobe while full", in_rd, 0);
      expect_data(0, 16'h9999, 14, 16'h0500, "R8");
      wait_idle();
      expect_all_empty("R8");
   endtask

   task automatic t_bad();     // R9
      push_pkt(5, 3, 16'hEEEE, 16'h0600);
      wait_idle();
      chk(err_bad_chan == 1'b1, "R9", "error flag set", err_bad_chan, 1);
      expect_all_empty("R9");
      push_pkt(1, 4, 16'h2468, 16'h0700);
      expect_data(1, 16'h2468, 4, 16'h0700, "R9");
      chk(err_bad_chan == 1'b1, "R9", "error flag sticky", err_bad_chan, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_cmd();
      t_interleave();
      t_clamp();
      t_zero();
      t_stall();
      t_bad();
      chk(rd_viol == 0, "R10", "read without valid", rd_viol, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule